// File: doc/BRIEF.md
# Multichannel Conversion Sequence Controller

This block runs conversion sequences over eight multiplexed analog inputs. It drives a converter core through a request/done handshake and stores each returned code in one of eight 16-bit result slots, which a bus-side reader selects with a slot index. A single configuration write sets the whole setup:
- power
- interrupt enable
- same-channel or stepping-channel mode
- one-shot or repeating scan
- sequence length
- 8- or 10-bit resolution
- left or right justification
- the starting channel
- whether starts come from an external trigger

After power is switched on, a recovery period of `RECOVERY_CYCLES` clocks must pass before the first request. Each configuration write cancels any sequence in progress and begins again at slot 0. Without the external-trigger option, that new sequence starts as soon as the converter is warm. With the option, it waits for a trigger pulse. When the last result of a sequence is stored, a completion flag is raised. The interrupt output follows that flag when the interrupt enable is set.

Top module: `scan_sequencer`

## Requirements
- R1: No conversion request is issued while power is off. After a write that turns power on from off, the first request is high in the cycle that follows the (RECOVERY_CYCLES+1)-th rising edge after the write edge. A write that leaves power on needs no new recovery: its first request follows the first edge after the write.
- R2: The length field `cfg_len` encodes the number of conversions per sequence: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Result slot k holds the k-th conversion of the sequence.
- R3: With `cfg_multi`=0, every conversion of a sequence uses channel `cfg_chan`.
- R4: With `cfg_multi`=1, conversion k uses channel (`cfg_chan` + k) mod 8, so the channel wraps from 7 to 0.
- R5: With `cfg_scan`=0, exactly one sequence runs. `busy` is low once its last result is stored, and no further request follows.
- R6: With `cfg_scan`=1, a new sequence starts right after each one ends, again from slot 0 and from `cfg_chan`, and `busy` stays high.
- R7: The slot value comes from the 10-bit `conv_code`. For 10 bits right-justified (`cfg_res10`=1, `cfg_right`=1) it is the code in bits 9:0. For 10 bits left-justified it is the code in bits 15:6. For 8 bits the value is code bits 9:2, placed in bits 7:0 when right-justified or in bits 15:8 when left-justified. All other bits are zero.
- R8: `seq_done` rises when the last result of a sequence is stored. It clears on a configuration write, or when slot 0 of a later sequence is stored unless that store is itself the last. `irq` equals `seq_done` gated by the interrupt enable.
- R9: A configuration write during a sequence abandons it. The next sequence writes slot 0 first, and slots it has not yet reached keep their old contents.
- R10: With `cfg_trig_en`=1, a write does not start a sequence. An `ext_trig` cycle while idle starts one. An `ext_trig` while busy is ignored.
- R11: `conv_req` is a one-cycle pulse with at most one conversion outstanding. The controller waits for `conv_done` however long that takes. A `conv_done` that arrives while no conversion is outstanding changes no slot and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_power | input | 1 | Power enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_multi | input | 1 | 1: step channels, 0: repeat one channel |
| cfg_scan | input | 1 | 1: repeat sequences, 0: one-shot |
| cfg_len | input | 2 | Sequence length code (1, 2, 4, 8) |
| cfg_res10 | input | 1 | 1: 10-bit results, 0: 8-bit |
| cfg_right | input | 1 | 1: right-justified, 0: left-justified |
| cfg_chan | input | 3 | Starting channel |
| cfg_trig_en | input | 1 | Start sequences on external trigger |
| ext_trig | input | 1 | External start trigger |
| conv_req | output | 1 | Conversion request pulse |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_done | input | 1 | Conversion finished, code valid |
| conv_code | input | 10 | Code returned by the converter |
| rd_slot | input | 3 | Result slot to read |
| rd_data | output | 16 | Contents of the selected slot |
| busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | Sequence-complete flag |
| irq | output | 1 | Completion interrupt |

## Verification
Two events meet on a single store when a sequence has length one. Storing slot 0 clears the completion flag, and storing the last result sets it, so the set must win. The bench runs a one-shot length-one sequence from the table and expects `seq_done` and `irq` high afterwards. In repeating scan, the last store of one sequence and the restart of the next also share a cycle. The bench checks that the flag drops at the next slot-0 store, rises again at the following end, and that both slots hold the second pass's codes.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int SLOTS           = 8,
  parameter int CODE_W          = 10,
  parameter int DATA_W          = 16,
  parameter int RECOVERY_CYCLES = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_power,
  input  logic                     cfg_irq_en,
  input  logic                     cfg_multi,
  input  logic                     cfg_scan,
  input  logic [1:0]               cfg_len,
  input  logic                     cfg_res10,
  input  logic                     cfg_right,
  input  logic [$clog2(SLOTS)-1:0] cfg_chan,
  input  logic                     cfg_trig_en,
  input  logic                     ext_trig,
  output logic                     conv_req,
  output logic [$clog2(SLOTS)-1:0] conv_chan,
  input  logic                     conv_done,
  input  logic [CODE_W-1:0]        conv_code,
  input  logic [$clog2(SLOTS)-1:0] rd_slot,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     busy,
  output logic                     seq_done,
  output logic                     irq
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int RC_W   = $clog2(RECOVERY_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_t;

  state_t              state;
  logic                pwr_q, ien_q, multi_q, scan_q, res10_q, right_q, xtrig_q;
  logic [1:0]          len_q;
  logic [SLOT_W-1:0]   chan_q, slot_q;
  logic [RC_W-1:0]     rec_cnt;
  logic                warm_q, pend_q, done_q;
  logic [DATA_W-1:0]   results [SLOTS];

  logic [SLOT_W:0]     seq_n;
  logic                last;
  logic [DATA_W-1:0]   fmt;

  assign seq_n = (SLOT_W+1)'(1) << len_q;
  assign last  = ({1'b0, slot_q} == seq_n - (SLOT_W+1)'(1));

  always_comb begin
    if (res10_q)
      fmt = right_q ? DATA_W'(conv_code)
                    : {conv_code, {(DATA_W-CODE_W){1'b0}}};
    else
      fmt = right_q ? DATA_W'(conv_code[CODE_W-1 -: 8])
                    : {conv_code[CODE_W-1 -: 8], {(DATA_W-8){1'b0}}};
  end

  assign conv_req  = (state == ST_REQ);
  assign conv_chan = multi_q ? chan_q + slot_q : chan_q;
  assign busy      = (state != ST_IDLE);
  assign seq_done  = done_q;
  assign irq       = done_q & ien_q;
  assign rd_data   = results[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pwr_q   <= 1'b0;
      ien_q   <= 1'b0;
      multi_q <= 1'b0;
      scan_q  <= 1'b0;
      res10_q <= 1'b0;
      right_q <= 1'b0;
      xtrig_q <= 1'b0;
      len_q   <= '0;
      chan_q  <= '0;
      slot_q  <= '0;
      rec_cnt <= '0;
      warm_q  <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      for (int i = 0; i < SLOTS; i++) results[i] <= '0;
    end else if (cfg_we) begin
      pwr_q   <= cfg_power;
      ien_q   <= cfg_irq_en;
      multi_q <= cfg_multi;
      scan_q  <= cfg_scan;
      res10_q <= cfg_res10;
      right_q <= cfg_right;
      xtrig_q <= cfg_trig_en;
      len_q   <= cfg_len;
      chan_q  <= cfg_chan;
      state   <= ST_IDLE;
      slot_q  <= '0;
      done_q  <= 1'b0;
      pend_q  <= cfg_power & ~cfg_trig_en;
      if (!cfg_power) begin
        warm_q  <= 1'b0;
        rec_cnt <= '0;
      end
    end else begin
      if (pwr_q && !warm_q) begin
        if (rec_cnt == RC_W'(RECOVERY_CYCLES - 1)) warm_q <= 1'b1;
        else rec_cnt <= rec_cnt + RC_W'(1);
      end
      if (xtrig_q && pwr_q && state == ST_IDLE && !pend_q && ext_trig)
        pend_q <= 1'b1;
      case (state)
        ST_IDLE: if (pend_q && warm_q) begin
          state  <= ST_REQ;
          slot_q <= '0;
          pend_q <= 1'b0;
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: if (conv_done) begin
          results[slot_q] <= fmt;
          if (slot_q == '0) done_q <= 1'b0;
          if (last) begin
            done_q <= 1'b1;
            slot_q <= '0;
            state  <= scan_q ? ST_REQ : ST_IDLE;
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
            state  <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_req,
  input logic [2:0] conv_chan,
  input logic       conv_done,
  input logic       seq_done,
  input logic       busy,
  input logic       pwr_q,
  input logic       warm_q,
  input logic       multi_q,
  input logic       scan_q,
  input logic [2:0] slot_q
);

  logic [2:0] last_chan;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_chan <= '0;
    else if (conv_req) last_chan <= conv_chan;
  end

  a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  a_r1_cold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (pwr_q && warm_q));

  a_r4_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && multi_q && slot_q != 3'd0) |-> conv_chan == 3'(last_chan + 3'd1));

  a_r3_same_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !multi_q && slot_q != 3'd0) |-> conv_chan == last_chan);

  a_r5_oneshot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(seq_done) && !scan_q) |-> !busy);

  a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(conv_done));

endmodule

bind scan_sequencer scan_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_chan(conv_chan),
  .conv_done(conv_done), .seq_done(seq_done), .busy(busy), .pwr_q(pwr_q),
  .warm_q(warm_q), .multi_q(multi_q), .scan_q(scan_q), .slot_q(slot_q)
);

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb;

  localparam int RECOV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_power = 0, cfg_irq_en = 0, cfg_multi = 0, cfg_scan = 0;
  logic [1:0] cfg_len = 0;
  logic cfg_res10 = 0, cfg_right = 0, cfg_trig_en = 0, ext_trig = 0;
  logic [2:0] cfg_chan = 0, rd_slot = 0;
  logic conv_req, busy, seq_done, irq;
  logic [2:0] conv_chan;
  logic [15:0] rd_data;
  logic conv_done;
  logic [9:0] conv_code;

  logic core_done = 0, mute = 0, fake = 0;
  logic [9:0] core_code = 0;
  logic [2:0] core_cnt = 0;
  int req_n = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  assign conv_done = core_done | fake;
  assign conv_code = fake ? 10'h2A5 : core_code;

  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_cnt != 0) begin
      core_cnt <= core_cnt - 3'd1;
      if (core_cnt == 3'd1) core_done <= 1'b1;
    end
    if (conv_req) begin
      req_n     <= req_n + 1;
      core_code <= {conv_chan, 7'(req_n)};
      if (!mute) core_cnt <= 3'd2;
    end
  end

  scan_sequencer #(.RECOVERY_CYCLES(RECOV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_power(cfg_power),
    .cfg_irq_en(cfg_irq_en), .cfg_multi(cfg_multi), .cfg_scan(cfg_scan),
    .cfg_len(cfg_len), .cfg_res10(cfg_res10), .cfg_right(cfg_right),
    .cfg_chan(cfg_chan), .cfg_trig_en(cfg_trig_en), .ext_trig(ext_trig),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_code(conv_code), .rd_slot(rd_slot), .rd_data(rd_data),
    .busy(busy), .seq_done(seq_done), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [9:0] c, input logic r10, input logic rj);
    logic [7:0] e;
    e = c[9:2];
    if (r10) return rj ? {6'd0, c} : {c, 6'd0};
    return rj ? {8'd0, e} : {e, 8'd0};
  endfunction

  task automatic write_cfg(input logic pw, ien, mu, sc, input logic [1:0] ln,
                           input logic r10, rj, input logic [2:0] ch, input logic te);
    @(negedge clk);
    cfg_power = pw; cfg_irq_en = ien; cfg_multi = mu; cfg_scan = sc; cfg_len = ln;
    cfg_res10 = r10; cfg_right = rj; cfg_chan = ch; cfg_trig_en = te; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_level(input logic lvl);
    for (int i = 0; i < 400 && seq_done != lvl; i++) @(negedge clk);
  endtask

  task automatic latency(output int k);
    k = 0;
    while (!conv_req && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic read_slot(input int s, output logic [15:0] d);
    rd_slot = 3'(s);
    #1 d = rd_data;
  endtask

  // [13] multi, [12:11] len, [10] res10, [9] right, [8:6] chan, [5] irq_en, [4:0] count
  localparam logic [13:0] VEC [6] = '{
    {1'b0, 2'd0, 1'b1, 1'b1, 3'd3, 1'b1, 5'd1},
    {1'b1, 2'd1, 1'b1, 1'b0, 3'd6, 1'b0, 5'd2},
    {1'b1, 2'd2, 1'b0, 1'b1, 3'd5, 1'b1, 5'd4},
    {1'b0, 2'd2, 1'b0, 1'b0, 3'd2, 1'b0, 5'd4},
    {1'b1, 2'd3, 1'b1, 1'b1, 3'd4, 1'b1, 5'd8},
    {1'b0, 2'd3, 1'b1, 1'b0, 3'd7, 1'b1, 5'd8}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k, base, base2;
    logic [15:0] d, old1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_slot(0, d);
    check("reset R8 seq_done", seq_done, 0);
    check("reset R8 irq", irq, 0);
    check("reset R11 conv_req", conv_req, 0);
    check("reset R5 busy", busy, 0);
    check("reset R7 rd_data", d, 0);

    // R1: off means quiet, then cold start recovery
    repeat (10) @(negedge clk);
    check("R1 no request while off", req_n, 0);
    write_cfg(1, 0, 0, 0, 2'd0, 1, 1, 3'd0, 0);
    latency(k);
    check("R1 cold start latency", k, RECOV + 1);
    wait_level(1);

    // table walk: R2 R3 R4 R5 R7 R8
    foreach (VEC[v]) begin
      logic mu, r10, rj, ien;
      logic [1:0] ln;
      logic [2:0] ch;
      int n;
      {mu, ln, r10, rj, ch, ien} = VEC[v][13:5];
      n = int'(VEC[v][4:0]);
      base = req_n;
      write_cfg(1, ien, mu, 0, ln, r10, rj, ch, 0);
      if (v == 0) begin
        latency(k);
        check("R1 warm restart latency", k, 1);
      end
      wait_level(1);
      for (int s = 0; s < n; s++) begin
        logic [2:0] ec;
        ec = mu ? 3'(ch + 3'(s)) : ch;
        read_slot(s, d);
        check(mu ? "R4 R2 R7 slot value" : "R3 R2 R7 slot value",
              d, fmt({ec, 7'(base + s)}, r10, rj));
      end
      check("R8 seq_done after last", seq_done, 1);
      check("R8 irq gating", irq, ien);
      repeat (10) @(negedge clk);
      check("R5 one-shot stops", busy, 0);
      check("R2 R5 request count", req_n - base, n);
    end

    // R6 continuous scan, multi, length 2 from channel 6
    base = req_n;
    write_cfg(1, 1, 1, 1, 2'd1, 1, 1, 3'd6, 0);
    wait_level(1);
    wait_level(0);
    check("R8 cleared at next slot 0", seq_done, 0);
    wait_level(1);
    mute = 1;
    read_slot(0, d);
    check("R6 second pass slot 0", d, {6'd0, 3'd6, 7'(base + 2)});
    read_slot(1, old1);
    check("R6 second pass slot 1", old1, {6'd0, 3'd7, 7'(base + 3)});
    check("R6 busy in scan", busy, 1);
    repeat (8) @(negedge clk);
    check("R11 waits for done", busy, 1);

    // R9 abort by write
    mute = 0;
    base2 = req_n;
    write_cfg(1, 0, 0, 0, 2'd0, 1, 1, 3'd1, 0);
    check("R9 R8 flag cleared on write", seq_done, 0);
    latency(k);
    check("R9 restart latency", k, 1);
    wait_level(1);
    read_slot(0, d);
    check("R9 restart writes slot 0", d, {6'd0, 3'd1, 7'(base2)});
    read_slot(1, d);
    check("R9 slot 1 kept", d, old1);

    // R11 stray done while idle
    @(negedge clk);
    fake = 1;
    @(negedge clk);
    fake = 0;
    repeat (2) @(negedge clk);
    read_slot(0, d);
    check("R11 stray done slot 0", d, {6'd0, 3'd1, 7'(base2)});
    read_slot(1, d);
    check("R11 stray done slot 1", d, old1);
    check("R11 stray done flag", seq_done, 1);

    // R10 external trigger
    base = req_n;
    write_cfg(1, 0, 0, 0, 2'd2, 1, 1, 3'd2, 1);
    repeat (10) @(negedge clk);
    check("R10 write does not start", req_n - base, 0);
    ext_trig = 1;
    @(negedge clk);
    ext_trig = 0;
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
    check("R10 trigger starts", busy, 1);
    repeat (3) @(negedge clk);
    ext_trig = 1;
    @(negedge clk);
    ext_trig = 0;
    wait_level(1);
    repeat (12) @(negedge clk);
    check("R10 trigger while busy ignored", req_n - base, 4);
    check("R10 idle after sequence", busy, 0);

    // R1 power off then cold again
    base = req_n;
    write_cfg(0, 0, 0, 0, 2'd0, 1, 1, 3'd0, 0);
    ext_trig = 1;
    repeat (20) @(negedge clk);
    ext_trig = 0;
    check("R1 quiet after power off", req_n - base, 0);
    write_cfg(1, 0, 0, 0, 2'd0, 1, 1, 3'd0, 0);
    latency(k);
    check("R1 recovery repeated", k, RECOV + 1);
    wait_level(1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule